// File: doc/BRIEF.md
# Real-Time Clock Timekeeping Core with Snapshot Read Buffers

This block keeps calendar time in packed BCD: seconds, minutes, hours in 24-hour form, day of week, date, month and two-digit year. A prescaler counts pulses of a free-running oscillator enable. Each full group of `DIV` pulses makes a one-second tick, and the tick ripples carries through the seven counters. Month lengths and leap years are handled in the date counter.

An external bus engine drives the block with single-cycle strobes: a START with its transfer direction, an acknowledge for each byte written, and an acknowledge or not-acknowledge for each byte read. Every START copies the live counters into a snapshot bank. All reads are served from that snapshot, so a multi-byte read returns one consistent time even if a tick lands in the middle of the transfer. In a write transfer, the first data byte loads the register pointer. Each later byte is committed into the live counter on its acknowledge strobe. A write to the seconds counter also restarts the sub-second prescaler.

Top module: `rtc_shadow_core`

## Requirements
- R1: After reset the time reads year 00, month 01, date 01, day-of-week 01, 00:00:00. The pointer is 0, `rd_valid` is low and `rd_data` is 00.
- R2: The snapshot bank is loaded from the live counters on every `bus_start` and on no other event. While `rd_valid` is high, `rd_data` shows the snapshot byte at the pointer: 0 seconds, 1 minutes, 2 hours, 3 day-of-week, 4 date, 5 month, 6 year.
- R3: A tick that occurs during an open read does not change any byte of that read. The next read after a new START shows the advanced time.
- R4: One seconds tick occurs per `DIV` `osc_en` pulses (default 32768). A committed write to address 0 clears the prescaler, so the next tick needs a further `DIV` pulses. The prescaler moves only on `osc_en` or a seconds write.
- R5: A written byte changes its live counter only in the cycle of its `wr_ack`. A byte on `wr_data` without `wr_ack` has no effect.
- R6: The first `wr_ack` after a write START loads the pointer; a value above 6 selects 0. The pointer advances after each committed write byte and each read byte acknowledged or not-acknowledged, wrapping from 6 to 0.
- R7: A `rd_nack` ends the read: from the next cycle `rd_valid` is low and `rd_data` is 00.
- R8: Seconds and minutes wrap 59 to 00, hours 23 to 00, day-of-week 7 to 1, month 12 to 01 and year 99 to 00. Each wrap carries into the next counter, with BCD digit carries.
- R9: The date wraps to 01 after 31 in months 01, 03, 05, 07, 08, 10 and 12, and after 30 in months 04, 06, 09 and 11. In month 02 it wraps after 29 when the year value is divisible by 4, and after 28 otherwise.
- R10: A full seven-byte write that starts with seconds and completes within one second sets the clock exactly to the written values.
- R11: When a write to a register and a tick fall in the same cycle, the written value is kept and the tick's increment of that register is dropped. Other registers still advance.
- R12: The live counters change only on a tick or a committed write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | Oscillator enable pulse counted by the prescaler |
| bus_start | input | 1 | START strobe; loads the snapshot bank |
| bus_rnw | input | 1 | Direction of the transfer opened by `bus_start`: 1 read, 0 write |
| wr_ack | input | 1 | Acknowledge strobe for the byte on `wr_data` |
| wr_data | input | 8 | Written byte (pointer or register value) |
| rd_ack | input | 1 | Host acknowledged the current read byte |
| rd_nack | input | 1 | Host not-acknowledged the final read byte |
| rd_data | output | 8 | Snapshot byte at the pointer, 00 when no read is open |
| rd_valid | output | 1 | A read transfer is open |

## Verification
On every cycle the assertions check four things. The snapshot bank holds between STARTs and takes the live values on each START. The live counters and the prescaler move only on an enable pulse or a committed write. A seconds write leaves the prescaler at zero and the written byte in the counter. The pointer stays inside 0 to 6, and a not-acknowledge closes the read. Other behaviours can only be shown by the bench's scenarios, because the result depends on the values involved. These are the calendar carries and month lengths, the leap-year rule, coherence of a read across a tick, pointer wrap on reads and writes, and the outcome of a write colliding with a tick.

// File: rtl/rtc_shadow_core.sv
module rtc_shadow_core #(
  parameter int DIV = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_en,
  input  logic       bus_start,
  input  logic       bus_rnw,
  input  logic       wr_ack,
  input  logic [7:0] wr_data,
  input  logic       rd_ack,
  input  logic       rd_nack,
  output logic [7:0] rd_data,
  output logic       rd_valid
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [6:0][7:0] RST_TIME = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  logic [PW-1:0]    pre_q;
  logic [6:0][7:0]  live_q, shad_q, tick_nx, live_d;
  logic [2:0]       ptr_q;
  logic             wr_open_q, wr_first_q, rd_valid_q;
  logic             c_sec, c_min, c_hr, c_date, c_mon;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v, input logic [7:0] top,
                                         input logic [7:0] base);
    if (v == top) return base;
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    logic [6:0] y;
    y = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
    case (mon)
      8'h02:                      return (y[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  wire       tick    = osc_en && (pre_q == PW'(DIV - 1));
  wire       commit  = wr_ack && wr_open_q && !wr_first_q;
  wire [2:0] ptr_inc = (ptr_q == 3'd6) ? 3'd0 : ptr_q + 3'd1;

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_valid_q ? shad_q[ptr_q] : 8'h00;

  always_comb begin
    c_sec  = live_q[0] == 8'h59;
    c_min  = c_sec && (live_q[1] == 8'h59);
    c_hr   = c_min && (live_q[2] == 8'h23);
    c_date = c_hr && (live_q[4] == month_len(live_q[5], live_q[6]));
    c_mon  = c_date && (live_q[5] == 8'h12);
    tick_nx = live_q;
    if (tick) begin
      tick_nx[0] = bcd_inc(live_q[0], 8'h59, 8'h00);
      if (c_sec) tick_nx[1] = bcd_inc(live_q[1], 8'h59, 8'h00);
      if (c_min) tick_nx[2] = bcd_inc(live_q[2], 8'h23, 8'h00);
      if (c_hr) begin
        tick_nx[3] = bcd_inc(live_q[3], 8'h07, 8'h01);
        tick_nx[4] = bcd_inc(live_q[4], month_len(live_q[5], live_q[6]), 8'h01);
      end
      if (c_date) tick_nx[5] = bcd_inc(live_q[5], 8'h12, 8'h01);
      if (c_mon)  tick_nx[6] = bcd_inc(live_q[6], 8'h99, 8'h00);
    end
    live_d = tick_nx;
    if (commit) live_d[ptr_q] = wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q      <= '0;
      live_q     <= RST_TIME;
      shad_q     <= RST_TIME;
      ptr_q      <= 3'd0;
      wr_open_q  <= 1'b0;
      wr_first_q <= 1'b0;
      rd_valid_q <= 1'b0;
    end else begin
      live_q <= live_d;
      if (commit && ptr_q == 3'd0) pre_q <= '0;
      else if (osc_en)             pre_q <= tick ? '0 : pre_q + PW'(1);
      if (bus_start) begin
        shad_q     <= live_q;
        wr_open_q  <= !bus_rnw;
        wr_first_q <= !bus_rnw;
        rd_valid_q <= bus_rnw;
      end else begin
        if (wr_ack && wr_open_q) begin
          if (wr_first_q) begin
            ptr_q      <= (wr_data < 8'd7) ? wr_data[2:0] : 3'd0;
            wr_first_q <= 1'b0;
          end else begin
            ptr_q <= ptr_inc;
          end
        end
        if ((rd_ack || rd_nack) && rd_valid_q) ptr_q <= ptr_inc;
        if (rd_nack) rd_valid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rtc_shadow_core_chk.sv
module rtc_shadow_core_chk #(
  parameter int PW = 15
) (
  input logic            clk,
  input logic            rst_n,
  input logic            osc_en,
  input logic            bus_start,
  input logic            wr_ack,
  input logic [7:0]      wr_data,
  input logic            rd_nack,
  input logic            rd_valid,
  input logic            wr_open_q,
  input logic            wr_first_q,
  input logic [2:0]      ptr_q,
  input logic [PW-1:0]   pre_q,
  input logic [6:0][7:0] live_q,
  input logic [6:0][7:0] shad_q
);
  wire wr_go  = wr_ack && wr_open_q && !wr_first_q;
  wire sec_go = wr_go && (ptr_q == 3'd0);

  a_r2_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_start |=> $stable(shad_q));
  a_r2_shadow_load: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> shad_q == $past(live_q));
  a_r4_presc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sec_go |=> pre_q == '0);
  a_r4_presc_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en && !sec_go |=> $stable(pre_q));
  a_r5_sec_commit: assert property (@(posedge clk) disable iff (!rst_n)
    sec_go |=> live_q[0] == $past(wr_data));
  a_r12_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en && !wr_go |=> $stable(live_q));
  a_r6_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= 3'd6);
  a_r7_nack_close: assert property (@(posedge clk) disable iff (!rst_n)
    rd_nack && !bus_start |=> !rd_valid);
endmodule

bind rtc_shadow_core rtc_shadow_core_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .bus_start(bus_start),
  .wr_ack(wr_ack), .wr_data(wr_data), .rd_nack(rd_nack), .rd_valid(rd_valid),
  .wr_open_q(wr_open_q), .wr_first_q(wr_first_q), .ptr_q(ptr_q),
  .pre_q(pre_q), .live_q(live_q), .shad_q(shad_q)
);

// File: tb/tb_rtc_shadow_core.sv
module tb_rtc_shadow_core;
  localparam int DIV = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic osc_en = 1'b0, bus_start = 1'b0, bus_rnw = 1'b0;
  logic wr_ack = 1'b0, rd_ack = 1'b0, rd_nack = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic rd_valid;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] rb [7];

  always #4 clk = ~clk;

  rtc_shadow_core #(.DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .bus_start(bus_start),
    .bus_rnw(bus_rnw), .wr_ack(wr_ack), .wr_data(wr_data), .rd_ack(rd_ack),
    .rd_nack(rd_nack), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic [6:0][7:0] tm(input logic [7:0] yr, mon, dt, dow, hr, mn, sc);
    return {yr, mon, dt, dow, hr, mn, sc};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic start_tx(input logic rnw);
    bus_start = 1'b1; bus_rnw = rnw;
    @(negedge clk);
    bus_start = 1'b0; bus_rnw = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] d);
    wr_ack = 1'b1; wr_data = d;
    @(negedge clk);
    wr_ack = 1'b0;
  endtask

  task automatic rack();
    rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0;
  endtask

  task automatic rnack();
    rd_nack = 1'b1; @(negedge clk); rd_nack = 1'b0;
  endtask

  task automatic osc(input int n);
    if (n > 0) begin
      osc_en = 1'b1;
      repeat (n) @(negedge clk);
      osc_en = 1'b0;
    end
  endtask

  task automatic set_ptr(input logic [7:0] a);
    start_tx(1'b0); wbyte(a);
  endtask

  task automatic set_time(input logic [6:0][7:0] t);
    set_ptr(8'h00);
    for (int i = 0; i < 7; i++) wbyte(t[i]);
  endtask

  task automatic check_time(input string req, input logic [6:0][7:0] exp);
    set_ptr(8'h00);
    start_tx(1'b1);
    for (int i = 0; i < 7; i++) begin
      rb[i] = rd_data;
      if (i < 6) rack(); else rnack();
    end
    for (int i = 0; i < 7; i++) check(req, rb[i], exp[i]);
  endtask

  task automatic roll_case(input string req, input logic [6:0][7:0] from, input logic [6:0][7:0] to);
    set_time(from);
    osc(DIV);
    check_time(req, to);
  endtask

  task automatic t_reset();
    check("R1 rd_valid", {7'd0, rd_valid}, 8'h00);
    check("R1 rd_data", rd_data, 8'h00);
    check_time("R1 time", tm(8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00));
  endtask

  task automatic t_write();
    set_time(tm(8'h24, 8'h06, 8'h15, 8'h03, 8'h12, 8'h34, 8'h56));
    check_time("R10 full set", tm(8'h24, 8'h06, 8'h15, 8'h03, 8'h12, 8'h34, 8'h56));
    set_ptr(8'h02);
    wr_data = 8'h77;
    repeat (3) @(negedge clk);
    wbyte(8'h05);
    check_time("R5 ack commit", tm(8'h24, 8'h06, 8'h15, 8'h03, 8'h05, 8'h34, 8'h56));
  endtask

  task automatic t_prescale();
    set_time(tm(8'h24, 8'h06, 8'h15, 8'h03, 8'h12, 8'h00, 8'h10));
    osc(DIV - 1);
    check_time("R4 before tick", tm(8'h24, 8'h06, 8'h15, 8'h03, 8'h12, 8'h00, 8'h10));
    osc(1);
    check_time("R4 tick", tm(8'h24, 8'h06, 8'h15, 8'h03, 8'h12, 8'h00, 8'h11));
    osc(DIV / 2);
    set_ptr(8'h00); wbyte(8'h20);
    osc(DIV - 1);
    check_time("R4 cleared", tm(8'h24, 8'h06, 8'h15, 8'h03, 8'h12, 8'h00, 8'h20));
    osc(1);
    check_time("R4 after clear", tm(8'h24, 8'h06, 8'h15, 8'h03, 8'h12, 8'h00, 8'h21));
  endtask

  task automatic t_rollover();
    roll_case("R8 all wrap", tm(8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59),
              tm(8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00));
    roll_case("R8 digit carry", tm(8'h05, 8'h03, 8'h10, 8'h02, 8'h09, 8'h59, 8'h59),
              tm(8'h05, 8'h03, 8'h10, 8'h02, 8'h10, 8'h00, 8'h00));
    roll_case("R8 minute", tm(8'h05, 8'h03, 8'h10, 8'h02, 8'h09, 8'h58, 8'h59),
              tm(8'h05, 8'h03, 8'h10, 8'h02, 8'h09, 8'h59, 8'h00));
  endtask

  task automatic t_months();
    roll_case("R9 feb plain", tm(8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59),
              tm(8'h23, 8'h03, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00));
    roll_case("R9 feb leap 28", tm(8'h24, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59),
              tm(8'h24, 8'h02, 8'h29, 8'h03, 8'h00, 8'h00, 8'h00));
    roll_case("R9 feb leap 29", tm(8'h24, 8'h02, 8'h29, 8'h03, 8'h23, 8'h59, 8'h59),
              tm(8'h24, 8'h03, 8'h01, 8'h04, 8'h00, 8'h00, 8'h00));
    roll_case("R9 year 00 leap", tm(8'h00, 8'h02, 8'h28, 8'h05, 8'h23, 8'h59, 8'h59),
              tm(8'h00, 8'h02, 8'h29, 8'h06, 8'h00, 8'h00, 8'h00));
    roll_case("R9 year 10 plain", tm(8'h10, 8'h02, 8'h28, 8'h05, 8'h23, 8'h59, 8'h59),
              tm(8'h10, 8'h03, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00));
    roll_case("R9 april", tm(8'h25, 8'h04, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59),
              tm(8'h25, 8'h05, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00));
    roll_case("R9 jan 30", tm(8'h25, 8'h01, 8'h30, 8'h04, 8'h23, 8'h59, 8'h59),
              tm(8'h25, 8'h01, 8'h31, 8'h05, 8'h00, 8'h00, 8'h00));
    roll_case("R9 jan 31", tm(8'h25, 8'h01, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59),
              tm(8'h25, 8'h02, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00));
  endtask

  task automatic t_coherent();
    set_time(tm(8'h25, 8'h05, 8'h05, 8'h01, 8'h08, 8'h14, 8'h59));
    osc(DIV - 1);
    set_ptr(8'h00);
    start_tx(1'b1);
    check("R3 sec", rd_data, 8'h59);
    rack();
    osc(1);
    check("R3 min after tick", rd_data, 8'h14);
    rack();
    check("R3 hour", rd_data, 8'h08);
    rnack();
    check_time("R2 fresh start", tm(8'h25, 8'h05, 8'h05, 8'h01, 8'h08, 8'h15, 8'h00));
  endtask

  task automatic t_pointer();
    set_time(tm(8'h31, 8'h08, 8'h17, 8'h06, 8'h21, 8'h42, 8'h03));
    set_ptr(8'h05);
    start_tx(1'b1);
    check("R6 rd month", rd_data, 8'h08); rack();
    check("R6 rd year", rd_data, 8'h31); rack();
    check("R6 rd wrap sec", rd_data, 8'h03); rack();
    check("R6 rd min", rd_data, 8'h42); rnack();
    check("R7 valid low", {7'd0, rd_valid}, 8'h00);
    check("R7 data zero", rd_data, 8'h00);
    start_tx(1'b1);
    check("R6 ptr kept", rd_data, 8'h21);
    rnack();
    set_ptr(8'h06); wbyte(8'h42); wbyte(8'h33);
    check_time("R6 wr wrap", tm(8'h42, 8'h08, 8'h17, 8'h06, 8'h21, 8'h42, 8'h33));
    set_ptr(8'h07); wbyte(8'h44);
    check_time("R6 ptr 7", tm(8'h42, 8'h08, 8'h17, 8'h06, 8'h21, 8'h42, 8'h44));
  endtask

  task automatic t_collide();
    set_time(tm(8'h25, 8'h07, 8'h20, 8'h04, 8'h06, 8'h10, 8'h30));
    osc(DIV - 1);
    set_ptr(8'h00);
    osc_en = 1'b1; wr_ack = 1'b1; wr_data = 8'h45;
    @(negedge clk);
    osc_en = 1'b0; wr_ack = 1'b0;
    check_time("R11 sec wins", tm(8'h25, 8'h07, 8'h20, 8'h04, 8'h06, 8'h10, 8'h45));
    osc(DIV - 1);
    check_time("R11 presc reset", tm(8'h25, 8'h07, 8'h20, 8'h04, 8'h06, 8'h10, 8'h45));
    osc(1);
    check_time("R11 next tick", tm(8'h25, 8'h07, 8'h20, 8'h04, 8'h06, 8'h10, 8'h46));
    osc(DIV - 1);
    set_ptr(8'h01);
    osc_en = 1'b1; wr_ack = 1'b1; wr_data = 8'h22;
    @(negedge clk);
    osc_en = 1'b0; wr_ack = 1'b0;
    check_time("R11 min wins", tm(8'h25, 8'h07, 8'h20, 8'h04, 8'h06, 8'h22, 8'h47));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_prescale();
    t_rollover();
    t_months();
    t_coherent();
    t_pointer();
    t_collide();
    finish_run();
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end
endmodule